// File: doc/BRIEF.md
# SD/MMC Host Command Register Frontend

This block is the memory-mapped register frontend of a simple SD/MMC host controller. Software writes the command argument, transfer geometry and buffer address through a 32-bit register port. It then writes a packed command word. That write decodes the word and sends a one-cycle start pulse to a backend command engine. The pulse carries the opcode, the response type, the command class, the bus-mode flags and the latched argument.

The backend reports completion, timeout and data-phase completion on single-cycle inputs. The frontend stores the response words and records each event as a sticky interrupt cause. Software clears a cause by writing 1 to its bit. A card-detect input is synchronised, and any change in it raises its own cause. One level interrupt combines all causes with an enable mask.

Top module: `sdmmc_regfront`

## Requirements
- R1: Registers sit at byte offsets 0x00 cause status, 0x04 cause enable, 0x08 buffer address, 0x0C command, 0x10 argument, 0x14/0x18/0x1C/0x20 response words 0..3, 0x24 block length, 0x28 block count and 0x2C card state. A read returns its data on `bus_rdata` in the cycle after the read strobe, and unmapped offsets read 0. Block length and block count keep only bits 10:0, which hold the value minus one. The command register reads back the last accepted command word in bits 15:0.
- R2: An accepted write to the command register gives exactly one cycle of `cmd_start`, in the cycle after the write. During that cycle the outputs carry the argument register value and these fields of the command word: opcode = bits 5:0, open-drain = bit 6, response type = bits 9:8 (0 none, 1 short, 2 long 136-bit, 3 short R3 kind), busy-wait = bit 11, class = bits 13:12 (0 broadcast, 1 broadcast with response, 2 addressed, 3 addressed with data), and read-from-card = bit 15.
- R3: A command write made while a command or its data phase is outstanding is ignored. It gives no start pulse, it leaves the command register as it was, and it leaves the cause bits unchanged.
- R4: Completion of an outstanding command sets cause bit 0. A timeout sets cause bit 3 and not bit 0, and it wins if both arrive together. Completion or timeout with no command outstanding is ignored.
- R5: On completion, response type 2 stores `eng_resp` bits 31:0, 63:32, 95:64 and 127:96 in response words 0, 1, 2 and 3. Types 1 and 3 store bits 31:0 in word 0 and zero words 1 to 3. Type 0 leaves all four words unchanged.
- R6: For class 3, cause bit 1 is set only by `data_done` arriving after the command has completed, and the block stays busy until then. A `data_done` at any other time, including after a timeout, is ignored.
- R7: Writing the cause status register clears each bit written as 1 and leaves each bit written as 0 unchanged. A new event in the same cycle wins over the clear.
- R8: `irq` is high exactly when some cause bit is set and its enable bit (same position at 0x04) is set. It changes in the same cycle as the status bits and the enable bits.
- R9: Card state bit 0 shows the synchronised `card_present` and bit 1 the synchronised `card_ro`. Every change of the synchronised present value sets cause bit 2.
- R10: After reset all registers read 0, and `irq` and `cmd_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt |
| cmd_start | output | 1 | One-cycle command launch |
| cmd_opcode | output | 6 | Command opcode |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp_type | output | 2 | Expected response type |
| cmd_class | output | 2 | Command class |
| cmd_open_drain | output | 1 | Open-drain bus mode |
| cmd_busy_wait | output | 1 | Wait for busy after response |
| cmd_read_dir | output | 1 | Data phase reads from card |
| blk_len | output | LEN_W | Block length minus one |
| blk_cnt | output | LEN_W | Block count minus one |
| buf_addr | output | 32 | Transfer buffer address |
| eng_done | input | 1 | Backend command completion pulse |
| eng_timeout | input | 1 | Backend command timeout pulse |
| eng_resp | input | 128 | Backend response bits, valid with eng_done |
| data_done | input | 1 | Backend data-phase completion pulse |
| card_present | input | 1 | Asynchronous card-detect level |
| card_ro | input | 1 | Asynchronous write-protect level |

## Verification
The assertions assume that `eng_done`, `eng_timeout` and `data_done` are single-cycle pulses. They also assume that register strobes are never presented together with an unrelated status write that could mask a cause falling. The bench drives every strobe and event for exactly one clock, changes inputs only at the falling edge, and waits several cycles after a card-detect change before sampling. It sweeps every response type, every command class and every combination of the three flag bits.

// File: rtl/sdmmc_regfront_pkg.sv
package sdmmc_regfront_pkg;
  localparam int OFS_STATUS = 'h00;
  localparam int OFS_ENABLE = 'h04;
  localparam int OFS_BUFFER = 'h08;
  localparam int OFS_CMD    = 'h0C;
  localparam int OFS_ARG    = 'h10;
  localparam int OFS_RSP0   = 'h14;
  localparam int OFS_BLEN   = 'h24;
  localparam int OFS_BCNT   = 'h28;
  localparam int OFS_CARD   = 'h2C;

  localparam int CAUSE_W    = 4;
  localparam int C_EOC      = 0;
  localparam int C_EOD      = 1;
  localparam int C_CARD     = 2;
  localparam int C_TMO      = 3;

  localparam int RSP_WORDS  = 4;
  localparam logic [1:0] RSP_NONE = 2'd0;
  localparam logic [1:0] RSP_LONG = 2'd2;
  localparam logic [1:0] CLS_DATA = 2'd3;

  typedef struct packed {
    logic       rd;
    logic [1:0] cls;
    logic       bsy;
    logic [1:0] rsp;
    logic       od;
    logic [5:0] opc;
  } cmd_fields_t;
endpackage

// File: rtl/sdmmc_cmd_seq.sv
module sdmmc_cmd_seq
  import sdmmc_regfront_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  cmd_fields_t dec,
  input  logic [31:0] arg_in,
  input  logic        eng_done,
  input  logic        eng_timeout,
  input  logic        data_done,
  output logic        accept,
  output logic        busy,
  output logic        start,
  output cmd_fields_t fields_q,
  output logic [31:0] arg_q,
  output logic        ev_eoc,
  output logic        ev_tmo,
  output logic        ev_eod
);
  logic cmd_active;
  logic data_pend;

  assign busy   = cmd_active | data_pend;
  assign accept = cmd_wr & ~busy;
  assign ev_tmo = cmd_active & eng_timeout;
  assign ev_eoc = cmd_active & eng_done & ~eng_timeout;
  assign ev_eod = data_pend & data_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_active <= 1'b0;
      data_pend  <= 1'b0;
      start      <= 1'b0;
      fields_q   <= '0;
      arg_q      <= '0;
    end else begin
      start <= accept;
      if (accept) begin
        fields_q   <= dec;
        arg_q      <= arg_in;
        cmd_active <= 1'b1;
      end
      if (cmd_active && (eng_done || eng_timeout)) begin
        cmd_active <= 1'b0;
        if (ev_eoc && fields_q.cls == CLS_DATA) data_pend <= 1'b1;
      end
      if (ev_eod) data_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sdmmc_resp_store.sv
module sdmmc_resp_store
  import sdmmc_regfront_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int TOT_W = WORD_W * RSP_WORDS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [1:0]       rsp_type,
  input  logic [TOT_W-1:0] resp_in,
  output logic [TOT_W-1:0] words
);
  for (genvar i = 0; i < RSP_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words[i*WORD_W +: WORD_W] <= '0;
      end else if (capture && rsp_type != RSP_NONE) begin
        if (rsp_type == RSP_LONG || i == 0)
          words[i*WORD_W +: WORD_W] <= resp_in[i*WORD_W +: WORD_W];
        else
          words[i*WORD_W +: WORD_W] <= '0;
      end
    end
  end
endmodule

// File: rtl/sdmmc_cause_ctrl.sv
module sdmmc_cause_ctrl
  import sdmmc_regfront_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [CAUSE_W-1:0] set_vec,
  input  logic               clr_wr,
  input  logic [CAUSE_W-1:0] clr_vec,
  input  logic               en_wr,
  input  logic [CAUSE_W-1:0] en_vec,
  output logic [CAUSE_W-1:0] status_q,
  output logic [CAUSE_W-1:0] enable_q,
  output logic               irq
);
  logic [CAUSE_W-1:0] status_d;
  logic [CAUSE_W-1:0] enable_d;

  always_comb begin
    status_d = status_q;
    if (clr_wr) status_d = status_d & ~clr_vec;
    status_d = status_d | set_vec;
    enable_d = en_wr ? en_vec : enable_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      irq      <= |(status_d & enable_d);
    end
  end
endmodule

// File: rtl/sdmmc_card_watch.sv
module sdmmc_card_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       present_in,
  input  logic       ro_in,
  output logic [1:0] state,
  output logic       change
);
  logic [1:0] chain [SYNC_STAGES];
  logic       prev_present;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else if (s == 0) chain[s] <= {ro_in, present_in};
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign state  = chain[SYNC_STAGES-1];
  assign change = state[0] ^ prev_present;

  always_ff @(posedge clk) begin
    if (rst) prev_present <= 1'b0;
    else prev_present <= state[0];
  end
endmodule

// File: rtl/sdmmc_regfront.sv
module sdmmc_regfront
  import sdmmc_regfront_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int LEN_W       = 11,
  parameter int SYNC_STAGES = 2,
  localparam int RSP_TOT    = 32 * RSP_WORDS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq,
  output logic               cmd_start,
  output logic [5:0]         cmd_opcode,
  output logic [31:0]        cmd_arg,
  output logic [1:0]         cmd_rsp_type,
  output logic [1:0]         cmd_class,
  output logic               cmd_open_drain,
  output logic               cmd_busy_wait,
  output logic               cmd_read_dir,
  output logic [LEN_W-1:0]   blk_len,
  output logic [LEN_W-1:0]   blk_cnt,
  output logic [31:0]        buf_addr,
  input  logic               eng_done,
  input  logic               eng_timeout,
  input  logic [RSP_TOT-1:0] eng_resp,
  input  logic               data_done,
  input  logic               card_present,
  input  logic               card_ro
);
  logic               sel_status, sel_enable, sel_buf, sel_cmd, sel_arg, sel_blen, sel_bcnt;
  logic [31:0]        arg_reg;
  logic [15:0]        cmd_word;
  cmd_fields_t        dec, fields_q;
  logic               accept_w, busy_w;
  logic               ev_eoc, ev_tmo, ev_eod;
  logic [RSP_TOT-1:0] rsp_words;
  logic [CAUSE_W-1:0] status_w, enable_w, set_vec;
  logic [1:0]         card_state;
  logic               card_change;
  logic [31:0]        rd_mux;

  assign sel_status = bus_wr && bus_addr == ADDR_W'(OFS_STATUS);
  assign sel_enable = bus_wr && bus_addr == ADDR_W'(OFS_ENABLE);
  assign sel_buf    = bus_wr && bus_addr == ADDR_W'(OFS_BUFFER);
  assign sel_cmd    = bus_wr && bus_addr == ADDR_W'(OFS_CMD);
  assign sel_arg    = bus_wr && bus_addr == ADDR_W'(OFS_ARG);
  assign sel_blen   = bus_wr && bus_addr == ADDR_W'(OFS_BLEN);
  assign sel_bcnt   = bus_wr && bus_addr == ADDR_W'(OFS_BCNT);

  assign dec.opc = bus_wdata[5:0];
  assign dec.od  = bus_wdata[6];
  assign dec.rsp = bus_wdata[9:8];
  assign dec.bsy = bus_wdata[11];
  assign dec.cls = bus_wdata[13:12];
  assign dec.rd  = bus_wdata[15];

  always_ff @(posedge clk) begin
    if (rst) begin
      arg_reg  <= '0;
      buf_addr <= '0;
      blk_len  <= '0;
      blk_cnt  <= '0;
      cmd_word <= '0;
    end else begin
      if (sel_arg)  arg_reg  <= bus_wdata;
      if (sel_buf)  buf_addr <= bus_wdata;
      if (sel_blen) blk_len  <= bus_wdata[LEN_W-1:0];
      if (sel_bcnt) blk_cnt  <= bus_wdata[LEN_W-1:0];
      if (accept_w) cmd_word <= bus_wdata[15:0];
    end
  end

  sdmmc_cmd_seq u_seq (
    .clk(clk), .rst(rst), .cmd_wr(sel_cmd), .dec(dec), .arg_in(arg_reg),
    .eng_done(eng_done), .eng_timeout(eng_timeout), .data_done(data_done),
    .accept(accept_w), .busy(busy_w), .start(cmd_start), .fields_q(fields_q),
    .arg_q(cmd_arg), .ev_eoc(ev_eoc), .ev_tmo(ev_tmo), .ev_eod(ev_eod)
  );

  assign cmd_opcode     = fields_q.opc;
  assign cmd_rsp_type   = fields_q.rsp;
  assign cmd_class      = fields_q.cls;
  assign cmd_open_drain = fields_q.od;
  assign cmd_busy_wait  = fields_q.bsy;
  assign cmd_read_dir   = fields_q.rd;

  sdmmc_resp_store #(.WORD_W(32)) u_rsp (
    .clk(clk), .rst(rst), .capture(ev_eoc), .rsp_type(fields_q.rsp),
    .resp_in(eng_resp), .words(rsp_words)
  );

  sdmmc_card_watch #(.SYNC_STAGES(SYNC_STAGES)) u_card (
    .clk(clk), .rst(rst), .present_in(card_present), .ro_in(card_ro),
    .state(card_state), .change(card_change)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[C_EOC]  = ev_eoc;
    set_vec[C_EOD]  = ev_eod;
    set_vec[C_CARD] = card_change;
    set_vec[C_TMO]  = ev_tmo;
  end

  sdmmc_cause_ctrl u_cause (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .clr_wr(sel_status), .clr_vec(bus_wdata[CAUSE_W-1:0]),
    .en_wr(sel_enable), .en_vec(bus_wdata[CAUSE_W-1:0]),
    .status_q(status_w), .enable_q(enable_w), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_STATUS)) rd_mux = 32'(status_w);
    if (bus_addr == ADDR_W'(OFS_ENABLE)) rd_mux = 32'(enable_w);
    if (bus_addr == ADDR_W'(OFS_BUFFER)) rd_mux = buf_addr;
    if (bus_addr == ADDR_W'(OFS_CMD))    rd_mux = 32'(cmd_word);
    if (bus_addr == ADDR_W'(OFS_ARG))    rd_mux = arg_reg;
    if (bus_addr == ADDR_W'(OFS_BLEN))   rd_mux = 32'(blk_len);
    if (bus_addr == ADDR_W'(OFS_BCNT))   rd_mux = 32'(blk_cnt);
    if (bus_addr == ADDR_W'(OFS_CARD))   rd_mux = 32'(card_state);
    for (int i = 0; i < RSP_WORDS; i++)
      if (bus_addr == ADDR_W'(OFS_RSP0 + 4 * i)) rd_mux = rsp_words[i*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sdmmc_regfront_chk.sv
module sdmmc_regfront_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wdata0,
  input logic              data_done,
  input logic              cmd_start,
  input logic              irq,
  input logic [3:0]        status,
  input logic [3:0]        enable,
  input logic              busy
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !cmd_start); // R2

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> $rose(busy)); // R3

  AST_EOD_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(status[1]) |-> $past(data_done)); // R6

  AST_EOC_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(status[0]) |-> $past(bus_wr && bus_addr == '0 && wdata0)); // R7

  AST_TMO_NOT_EOC: assert property (@(posedge clk) disable iff (rst)
    $rose(status[3]) |-> !$rose(status[0])); // R4

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (enable == 4'd0) |-> !irq); // R8

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status != 4'd0)); // R8
endmodule

bind sdmmc_regfront sdmmc_regfront_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wdata0(bus_wdata[0]), .data_done(data_done), .cmd_start(cmd_start),
  .irq(irq), .status(status_w), .enable(enable_w), .busy(busy_w)
);

// File: tb/sdmmc_regfront_test.sv
module sdmmc_regfront_test;
  localparam int ADDR_W = 6;
  localparam int LEN_W  = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, cmd_start, cmd_open_drain, cmd_busy_wait, cmd_read_dir;
  logic [5:0] cmd_opcode;
  logic [31:0] cmd_arg, buf_addr;
  logic [1:0] cmd_rsp_type, cmd_class;
  logic [LEN_W-1:0] blk_len, blk_cnt;
  logic eng_done = 0, eng_timeout = 0, data_done = 0;
  logic [127:0] eng_resp = '0;
  logic card_present = 0, card_ro = 0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [31:0] model_rsp [4];

  always #2.5 clk = ~clk;

  sdmmc_regfront #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .cmd_start(cmd_start),
    .cmd_opcode(cmd_opcode), .cmd_arg(cmd_arg), .cmd_rsp_type(cmd_rsp_type),
    .cmd_class(cmd_class), .cmd_open_drain(cmd_open_drain), .cmd_busy_wait(cmd_busy_wait),
    .cmd_read_dir(cmd_read_dir), .blk_len(blk_len), .blk_cnt(blk_cnt), .buf_addr(buf_addr),
    .eng_done(eng_done), .eng_timeout(eng_timeout), .eng_resp(eng_resp),
    .data_done(data_done), .card_present(card_present), .card_ro(card_ro)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic pulse_done(input logic [127:0] r);
    eng_done = 1; eng_resp = r;
    @(negedge clk);
    eng_done = 0;
  endtask

  task automatic pulse_tmo();
    eng_timeout = 1;
    @(negedge clk);
    eng_timeout = 0;
  endtask

  task automatic pulse_data();
    data_done = 1;
    @(negedge clk);
    data_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w, a;
    logic [127:0] r;
    for (int k = 0; k < 4; k++) model_rsp[k] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R10: reset values on every mapped offset
    for (int o = 0; o <= 'h2C; o += 4) begin
      rd(o, v);
      chk("R10 reset read", v, 0);
    end
    chk("R10 irq low", 32'(irq), 0);
    chk("R10 start low", 32'(cmd_start), 0);

    // R1: plain registers and masking
    wr('h08, 32'hDEAD_BEE0); rd('h08, v); chk("R1 buffer", v, 32'hDEAD_BEE0);
    chk("R1 buf port", buf_addr, 32'hDEAD_BEE0);
    wr('h24, 32'hFFFF_F123); rd('h24, v); chk("R1 blen mask", v, 32'h123);
    chk("R1 blen port", 32'(blk_len), 32'h123);
    wr('h28, 32'h0000_07FF); rd('h28, v); chk("R1 bcnt max", v, 32'h7FF);
    chk("R1 bcnt port", 32'(blk_cnt), 32'h7FF);
    wr('h10, 32'h1234_5678); rd('h10, v); chk("R1 arg", v, 32'h1234_5678);
    rd('h30, v); chk("R1 unmapped", v, 0);

    // R2 R4 R5 R6: sweep response type, class and flag bits
    for (int i = 0; i < 128; i++) begin
      int rt, cl, fl, opc;
      rt = i / 32; cl = (i / 8) % 4; fl = i % 8; opc = (i * 7 + 3) % 64;
      w = 32'(opc) | (32'(fl & 1) << 6) | (32'(rt) << 8) | (32'((fl >> 1) & 1) << 11)
        | (32'(cl) << 12) | (32'((fl >> 2) & 1) << 15);
      a = 32'hA500_0000 + 32'(i * 13);
      wr('h10, a);
      wr('h0C, w);
      chk("R2 start pulse", 32'(cmd_start), 1);
      chk("R2 fields", {cmd_read_dir, cmd_class, cmd_busy_wait, cmd_rsp_type, cmd_open_drain, cmd_opcode},
          32'(((w >> 15) & 1) << 12 | ((w >> 12) & 3) << 10 | ((w >> 11) & 1) << 9
              | ((w >> 8) & 3) << 7 | ((w >> 6) & 1) << 6 | (w & 63)));
      chk("R2 arg", cmd_arg, a);
      @(negedge clk);
      chk("R2 single cycle", 32'(cmd_start), 0);
      rd('h0C, v); chk("R1 cmd readback", v, w & 32'hFFFF);
      r = {32'h3000_0000 + 32'(i), 32'h2000_0000 + 32'(i), 32'h1000_0000 + 32'(i), 32'h0F00_0000 + 32'(i)};
      pulse_done(r);
      if (rt == 2) for (int k = 0; k < 4; k++) model_rsp[k] = r[k*32 +: 32];
      else if (rt != 0) begin
        model_rsp[0] = r[31:0];
        for (int k = 1; k < 4; k++) model_rsp[k] = 0;
      end
      rd('h00, v);
      chk("R4 R6 eoc only", v, 1);
      if (cl == 3) begin
        pulse_data();
        rd('h00, v); chk("R6 eod after data", v, 3);
      end
      rd('h14, v); chk("R5 word0", v, model_rsp[0]);
      rd('h20, v); chk("R5 word3", v, model_rsp[3]);
      if (rt == 2) begin rd('h18, v); chk("R5 word1", v, model_rsp[1]);
        rd('h1C, v); chk("R5 word2", v, model_rsp[2]); end
      wr('h00, 32'hF);
    end

    // R3: write while busy ignored
    wr('h0C, 32'h0000_3111);
    @(negedge clk);
    wr('h0C, 32'h0000_0222);
    chk("R3 no second start", 32'(cmd_start), 0);
    rd('h0C, v); chk("R3 cmd kept", v, 32'h3111);
    rd('h00, v); chk("R3 status kept", v, 0);
    // R6: data_done while command still active is ignored
    pulse_data();
    rd('h00, v); chk("R6 early data ignored", v, 0);
    pulse_done('0);
    wr('h0C, 32'h0000_0105);
    chk("R6 busy until data", 32'(cmd_start), 0);
    pulse_data();
    rd('h00, v); chk("R6 eod", v, 3);
    wr('h00, 32'hF);

    // R4: timeout wins, even over simultaneous done
    wr('h0C, 32'h0000_3101);
    eng_done = 1; eng_timeout = 1;
    @(negedge clk);
    eng_done = 0; eng_timeout = 0;
    rd('h00, v); chk("R4 timeout only", v, 8);
    pulse_data();
    rd('h00, v); chk("R6 data after timeout ignored", v, 8);
    pulse_done('0);
    rd('h00, v); chk("R4 idle done ignored", v, 8);

    // R7: write-one-to-clear
    wr('h0C, 32'h0000_0101); pulse_done('0);
    rd('h00, v); chk("R7 both set", v, 9);
    wr('h00, 32'h1); rd('h00, v); chk("R7 clear bit0", v, 8);
    wr('h00, 32'h0); rd('h00, v); chk("R7 zero keeps", v, 8);
    // R8: interrupt masking
    chk("R8 masked", 32'(irq), 0);
    wr('h04, 32'h8);
    chk("R8 enabled", 32'(irq), 1);
    wr('h04, 32'h1);
    chk("R8 other mask", 32'(irq), 0);
    wr('h04, 32'h8);
    wr('h00, 32'h8);
    chk("R8 cleared", 32'(irq), 0);
    rd('h00, v); chk("R7 clear bit3", v, 0);

    // R9: card detect
    wr('h04, 32'h4);
    card_present = 1; card_ro = 1;
    repeat (6) @(negedge clk);
    rd('h2C, v); chk("R9 state", v, 3);
    rd('h00, v); chk("R9 change", v, 4);
    chk("R9 irq", 32'(irq), 1);
    wr('h00, 32'h4);
    card_present = 0;
    repeat (6) @(negedge clk);
    rd('h2C, v); chk("R9 removed", v, 2);
    rd('h00, v); chk("R9 remove change", v, 4);
    card_ro = 0; wr('h00, 32'h4);
    repeat (6) @(negedge clk);
    rd('h00, v); chk("R9 ro no cause", v, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule